// File: doc/BRIEF.md
# Flash Byte Program Engine

This block writes a run of bytes into a byte-wide NOR flash. A request carries a start address and a byte count. The bytes then arrive one at a time on a valid/ready stream and go to consecutive addresses. For each byte the engine first reads the target. If the target already holds the wanted value, no write is issued. Otherwise the engine sends the three-write unlock/program command, writes the byte, and polls the location until two consecutive reads agree. The final read is then compared with the intended byte.

A request that would run past the end of the device is refused before any flash access. Processing stops at the first byte that fails to program. At the end of every request a single-cycle `done` reports two things: a result code and the number of bytes that completed. A separate one-cycle `warn` pulse marks any byte that tries to turn a stored 0 back into a 1. The engine still attempts the write in that case.

The flash port is a simple synchronous strobe bus. A read strobe returns its data on `fl_rdata` in the following cycle. A write strobe takes effect on the clock edge where it is high.

Top module: `flash_byte_prog`

## Requirements
- R1: A byte whose target already reads back equal to it is not written: no write strobe is issued for it, and it still counts as completed.
- R2: When the old contents and the new byte satisfy `(~old & new) != 0`, `warn` pulses for exactly one cycle and the program sequence is still issued for that byte. Otherwise `warn` stays low.
- R3: A program operation is four write strobes on consecutive cycles, in this order: 0xAA to address 0x555, 0x55 to address 0x2AA, 0xA0 to address 0x555, then the data byte to the target address.
- R4: After the data write, the target is read at least three times. Polling ends at the first read that equals the read before it, provided at least three reads have been made.
- R5: Polling is capped at POLL_LIMIT reads after the data write (default 10000). When the cap is reached, the last read is evaluated as the final value.
- R6: If the final read differs from the data byte, the request fails. The code is 2'b10 (internal fault) when bit 5 of the read made two before the final read is set. Otherwise the code is 2'b11 (not programmed). On success the code is 2'b00.
- R7: A request whose start plus length exceeds DEV_BYTES completes with code 2'b01. It causes no flash strobe and takes no stream byte. A request ending exactly at DEV_BYTES is accepted.
- R8: Processing stops at the first failed byte, and the rest of the stream is not taken. `bytes_done` equals the number of bytes completed before the failure. `done` is high for exactly one cycle per request.
- R9: Stream bytes go to consecutive addresses starting at the request address. A zero-length request completes with code 2'b00, `bytes_done` 0 and no flash strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Engine idle, request accepted when both high |
| req_addr | input | AW | First target address |
| req_len | input | AW+1 | Number of bytes |
| dat_valid | input | 1 | Stream byte offered |
| dat_ready | output | 1 | Engine takes the stream byte |
| dat_byte | input | 8 | Stream byte |
| fl_stb | output | 1 | Flash access strobe |
| fl_we | output | 1 | Access is a write when high |
| fl_addr | output | AW | Flash address |
| fl_wdata | output | 8 | Flash write data |
| fl_rdata | input | 8 | Flash read data, valid the cycle after a read strobe |
| warn | output | 1 | One-cycle flag: a 0 bit would have to become 1 |
| done | output | 1 | One-cycle request completion |
| err_code | output | 2 | Result code, valid with done |
| bytes_done | output | AW+1 | Bytes completed, valid with done |

## Verification
A corrupted sequencer state shows on the flash bus within one or two cycles. It appears as a command write out of order, a data write without its unlock prefix, or a stream handshake that overlaps a flash access.

Errors in the poll counter or the status history only appear at the end of polling. They show as a read count that differs from the busy length plus two, or from the cap. They also show as the wrong cause code, which is visible only with `done`.

A wrong byte counter or address register is caught through the contents of the target locations and through `bytes_done` at `done`. This is why the directed cases are built to fail partway through a multi-byte run.

// File: rtl/fbp_pkg.sv
package fbp_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_CHECK,
    ST_FETCH,
    ST_RD_OLD,
    ST_CMP_OLD,
    ST_UNL0,
    ST_UNL1,
    ST_PCMD,
    ST_PDATA,
    ST_POLL_RD,
    ST_POLL_CAP,
    ST_NEXT,
    ST_FIN
  } fbp_state_e;

  typedef enum logic [1:0] {
    RES_OK     = 2'b00,
    RES_RANGE  = 2'b01,
    RES_FAULT  = 2'b10,
    RES_NOPROG = 2'b11
  } fbp_res_e;

  localparam logic [7:0]  UNLK_BYTE_A = 8'hAA;
  localparam logic [7:0]  UNLK_BYTE_B = 8'h55;
  localparam logic [7:0]  PROG_BYTE   = 8'hA0;
  localparam int unsigned CMD_ADDR_A  = 32'h555;
  localparam int unsigned CMD_ADDR_B  = 32'h2AA;
  localparam int unsigned FAULT_BIT   = 5;

endpackage

// File: rtl/fbp_rst_sync.sv
module fbp_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];

endmodule

// File: rtl/fbp_range.sv
module fbp_range #(
  parameter int AW        = 16,
  parameter int LW        = AW + 1,
  parameter int DEV_BYTES = 1 << AW
) (
  input  logic [AW-1:0] start,
  input  logic [LW-1:0] len,
  output logic          over
);

  localparam int SW = LW + 1;

  logic [SW-1:0] end_excl;
  logic [SW-1:0] limit;

  assign end_excl = {{(SW-AW){1'b0}}, start} + {1'b0, len};
  assign limit    = SW'(DEV_BYTES);
  assign over     = end_excl > limit;

endmodule

// File: rtl/fbp_history.sv
module fbp_history #(
  parameter int W        = 8,
  parameter int DEPTH    = 4,
  parameter int FLAG_BIT = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         push,
  input  logic [W-1:0] din,
  output logic [W-1:0] last,
  output logic         prev_flag
);

  localparam int PW = $clog2(DEPTH);

  logic [W-1:0]  ent_q [DEPTH];
  logic [PW-1:0] wptr_q;
  logic [PW-1:0] wptr_d;
  logic          wptr_en;

  assign wptr_en = clr | push;
  assign wptr_d  = clr ? '0 : wptr_q + PW'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       wptr_q <= '0;
    else if (wptr_en) wptr_q <= wptr_d;
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    logic ent_en;
    assign ent_en = push && (wptr_q == PW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ent_q[g] <= '0;
      else if (ent_en) ent_q[g] <= din;
    end
  end

  logic [W-1:0] prev_ent;
  assign last      = ent_q[wptr_q - PW'(1)];
  assign prev_ent  = ent_q[wptr_q - PW'(2)];
  assign prev_flag = prev_ent[FLAG_BIT];

endmodule

// File: rtl/fbp_ctrl.sv
module fbp_ctrl
  import fbp_pkg::*;
#(
  parameter int AW         = 16,
  parameter int LW         = AW + 1,
  parameter int POLL_LIMIT = 10000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_addr,
  input  logic [LW-1:0] req_len,
  input  logic          range_over,
  input  logic          dat_valid,
  output logic          dat_ready,
  input  logic [7:0]    dat_byte,
  output logic          fl_stb,
  output logic          fl_we,
  output logic [AW-1:0] fl_addr,
  output logic [7:0]    fl_wdata,
  input  logic [7:0]    fl_rdata,
  output logic          hist_clr,
  output logic          hist_push,
  input  logic [7:0]    hist_last,
  input  logic          hist_prev_flag,
  output logic          warn,
  output logic          done,
  output logic [1:0]    err_code,
  output logic [LW-1:0] bytes_done
);

  localparam int CW = $clog2(POLL_LIMIT + 1);
  localparam logic [CW-1:0] PCNT_LAST = CW'(POLL_LIMIT - 1);
  localparam logic [CW-1:0] PCNT_MIN  = CW'(2);

  fbp_state_e    state_q, state_d;
  logic [AW-1:0] addr_q, addr_d;
  logic [LW-1:0] rem_q, rem_d;
  logic [LW-1:0] cnt_q, cnt_d;
  logic [7:0]    byte_q, byte_d;
  logic          bad_q, bad_d;
  fbp_res_e      res_q, res_d;
  logic [CW-1:0] pcnt_q, pcnt_d;
  logic          warn_q, warn_d;
  logic          poll_end;

  assign poll_end = (pcnt_q >= PCNT_MIN) &&
                    ((fl_rdata == hist_last) || (pcnt_q >= PCNT_LAST));

  always_comb begin
    state_d   = state_q;
    addr_d    = addr_q;
    rem_d     = rem_q;
    cnt_d     = cnt_q;
    byte_d    = byte_q;
    bad_d     = bad_q;
    res_d     = res_q;
    pcnt_d    = pcnt_q;
    warn_d    = 1'b0;
    req_ready = 1'b0;
    dat_ready = 1'b0;
    fl_stb    = 1'b0;
    fl_we     = 1'b0;
    fl_addr   = addr_q;
    fl_wdata  = byte_q;
    hist_clr  = 1'b0;
    hist_push = 1'b0;
    done      = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        req_ready = 1'b1;
        if (req_valid) begin
          addr_d  = req_addr;
          rem_d   = req_len;
          cnt_d   = '0;
          bad_d   = range_over;
          res_d   = RES_OK;
          state_d = ST_CHECK;
        end
      end
      ST_CHECK: begin
        if (bad_q) begin
          res_d   = RES_RANGE;
          state_d = ST_FIN;
        end else if (rem_q == '0) begin
          state_d = ST_FIN;
        end else begin
          state_d = ST_FETCH;
        end
      end
      ST_FETCH: begin
        dat_ready = 1'b1;
        if (dat_valid) begin
          byte_d  = dat_byte;
          state_d = ST_RD_OLD;
        end
      end
      ST_RD_OLD: begin
        fl_stb  = 1'b1;
        state_d = ST_CMP_OLD;
      end
      ST_CMP_OLD: begin
        if (fl_rdata == byte_q) begin
          state_d = ST_NEXT;
        end else begin
          warn_d  = |(~fl_rdata & byte_q);
          state_d = ST_UNL0;
        end
      end
      ST_UNL0: begin
        fl_stb   = 1'b1;
        fl_we    = 1'b1;
        fl_addr  = AW'(CMD_ADDR_A);
        fl_wdata = UNLK_BYTE_A;
        state_d  = ST_UNL1;
      end
      ST_UNL1: begin
        fl_stb   = 1'b1;
        fl_we    = 1'b1;
        fl_addr  = AW'(CMD_ADDR_B);
        fl_wdata = UNLK_BYTE_B;
        state_d  = ST_PCMD;
      end
      ST_PCMD: begin
        fl_stb   = 1'b1;
        fl_we    = 1'b1;
        fl_addr  = AW'(CMD_ADDR_A);
        fl_wdata = PROG_BYTE;
        state_d  = ST_PDATA;
      end
      ST_PDATA: begin
        fl_stb   = 1'b1;
        fl_we    = 1'b1;
        hist_clr = 1'b1;
        pcnt_d   = '0;
        state_d  = ST_POLL_RD;
      end
      ST_POLL_RD: begin
        fl_stb  = 1'b1;
        state_d = ST_POLL_CAP;
      end
      ST_POLL_CAP: begin
        hist_push = 1'b1;
        pcnt_d    = pcnt_q + CW'(1);
        if (!poll_end) begin
          state_d = ST_POLL_RD;
        end else if (fl_rdata == byte_q) begin
          state_d = ST_NEXT;
        end else begin
          res_d   = hist_prev_flag ? RES_FAULT : RES_NOPROG;
          state_d = ST_FIN;
        end
      end
      ST_NEXT: begin
        cnt_d   = cnt_q + LW'(1);
        addr_d  = addr_q + AW'(1);
        rem_d   = rem_q - LW'(1);
        state_d = (rem_q == LW'(1)) ? ST_FIN : ST_FETCH;
      end
      ST_FIN: begin
        done    = 1'b1;
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      rem_q   <= '0;
      cnt_q   <= '0;
      byte_q  <= '0;
      bad_q   <= 1'b0;
      res_q   <= RES_OK;
      pcnt_q  <= '0;
      warn_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      addr_q  <= addr_d;
      rem_q   <= rem_d;
      cnt_q   <= cnt_d;
      byte_q  <= byte_d;
      bad_q   <= bad_d;
      res_q   <= res_d;
      pcnt_q  <= pcnt_d;
      warn_q  <= warn_d;
    end
  end

  assign warn       = warn_q;
  assign err_code   = res_q;
  assign bytes_done = cnt_q;

endmodule

// File: rtl/flash_byte_prog.sv
module flash_byte_prog
  import fbp_pkg::*;
#(
  parameter int AW         = 16,
  parameter int DEV_BYTES  = 1 << AW,
  parameter int POLL_LIMIT = 10000,
  parameter int HIST_DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_addr,
  input  logic [AW:0]   req_len,
  input  logic          dat_valid,
  output logic          dat_ready,
  input  logic [7:0]    dat_byte,
  output logic          fl_stb,
  output logic          fl_we,
  output logic [AW-1:0] fl_addr,
  output logic [7:0]    fl_wdata,
  input  logic [7:0]    fl_rdata,
  output logic          warn,
  output logic          done,
  output logic [1:0]    err_code,
  output logic [AW:0]   bytes_done
);

  localparam int LW = AW + 1;

  logic       rst_n_i;
  logic       range_over;
  logic       hist_clr;
  logic       hist_push;
  logic [7:0] hist_last;
  logic       hist_prev_flag;

  fbp_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_i)
  );

  fbp_range #(.AW(AW), .LW(LW), .DEV_BYTES(DEV_BYTES)) u_range (
    .start (req_addr),
    .len   (req_len),
    .over  (range_over)
  );

  fbp_history #(.W(8), .DEPTH(HIST_DEPTH), .FLAG_BIT(FAULT_BIT)) u_hist (
    .clk       (clk),
    .rst_n     (rst_n_i),
    .clr       (hist_clr),
    .push      (hist_push),
    .din       (fl_rdata),
    .last      (hist_last),
    .prev_flag (hist_prev_flag)
  );

  fbp_ctrl #(.AW(AW), .LW(LW), .POLL_LIMIT(POLL_LIMIT)) u_ctrl (
    .clk            (clk),
    .rst_n          (rst_n_i),
    .req_valid      (req_valid),
    .req_ready      (req_ready),
    .req_addr       (req_addr),
    .req_len        (req_len),
    .range_over     (range_over),
    .dat_valid      (dat_valid),
    .dat_ready      (dat_ready),
    .dat_byte       (dat_byte),
    .fl_stb         (fl_stb),
    .fl_we          (fl_we),
    .fl_addr        (fl_addr),
    .fl_wdata       (fl_wdata),
    .fl_rdata       (fl_rdata),
    .hist_clr       (hist_clr),
    .hist_push      (hist_push),
    .hist_last      (hist_last),
    .hist_prev_flag (hist_prev_flag),
    .warn           (warn),
    .done           (done),
    .err_code       (err_code),
    .bytes_done     (bytes_done)
  );

endmodule

// File: rtl/fbp_checker.sv
module fbp_checker
  import fbp_pkg::*;
#(
  parameter int AW         = 16,
  parameter int POLL_LIMIT = 10000
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic          dat_valid,
  input logic          dat_ready,
  input logic          fl_stb,
  input logic          fl_we,
  input logic [AW-1:0] fl_addr,
  input logic [7:0]    fl_wdata,
  input logic          warn,
  input logic          done,
  input logic [1:0]    err_code
);

  logic quiet_q;
  int   rd_cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     quiet_q <= 1'b1;
    else if (req_valid && req_ready) quiet_q <= 1'b1;
    else if (fl_stb)                quiet_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      rd_cnt_q <= 0;
    else if (fl_stb && fl_we)        rd_cnt_q <= 0;
    else if (dat_valid && dat_ready) rd_cnt_q <= 0;
    else if (fl_stb)                 rd_cnt_q <= rd_cnt_q + 1;
  end

  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_range_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && err_code == 2'b01) |-> quiet_q);

  assert_warn_then_unlock_R2: assert property (@(posedge clk) disable iff (!rst_n)
    warn |-> (fl_stb && fl_we && fl_addr == AW'(CMD_ADDR_A) && fl_wdata == UNLK_BYTE_A));

  assert_write_run_head_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fl_we) |-> (fl_stb && fl_addr == AW'(CMD_ADDR_A) && fl_wdata == UNLK_BYTE_A));

  assert_write_run_order_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fl_we) |=> (fl_we && fl_addr == AW'(CMD_ADDR_B) && fl_wdata == UNLK_BYTE_B)
                     ##1 (fl_we && fl_addr == AW'(CMD_ADDR_A) && fl_wdata == PROG_BYTE)
                     ##1 fl_we ##1 !fl_we);

  assert_min_polls_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fl_we) |-> (fl_stb && !fl_we) ##2 (fl_stb && !fl_we) ##2 (fl_stb && !fl_we));

  assert_poll_cap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_stb && !fl_we) |-> (rd_cnt_q < POLL_LIMIT));

  assert_stream_apart_R9: assert property (@(posedge clk) disable iff (!rst_n)
    dat_ready |-> !fl_stb);

endmodule

bind flash_byte_prog fbp_checker #(.AW(AW), .POLL_LIMIT(POLL_LIMIT)) u_fbp_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .dat_valid (dat_valid),
  .dat_ready (dat_ready),
  .fl_stb    (fl_stb),
  .fl_we     (fl_we),
  .fl_addr   (fl_addr),
  .fl_wdata  (fl_wdata),
  .warn      (warn),
  .done      (done),
  .err_code  (err_code)
);

// File: tb/tb_flash_byte_prog.sv
module tb_flash_byte_prog;

  localparam int AW   = 12;
  localparam int DEV  = 4096;
  localparam int PLIM = 10000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [AW-1:0] req_addr = '0;
  logic [AW:0]   req_len = '0;
  logic          dat_valid = 1'b0;
  logic          dat_ready;
  logic [7:0]    dat_byte = '0;
  logic          fl_stb, fl_we;
  logic [AW-1:0] fl_addr;
  logic [7:0]    fl_wdata;
  logic [7:0]    fl_rdata = '0;
  logic          warn, done;
  logic [1:0]    err_code;
  logic [AW:0]   bytes_done;

  always #2 clk = ~clk;

  flash_byte_prog #(.AW(AW), .DEV_BYTES(DEV), .POLL_LIMIT(PLIM)) dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr), .req_len(req_len),
    .dat_valid(dat_valid), .dat_ready(dat_ready), .dat_byte(dat_byte),
    .fl_stb(fl_stb), .fl_we(fl_we), .fl_addr(fl_addr), .fl_wdata(fl_wdata), .fl_rdata(fl_rdata),
    .warn(warn), .done(done), .err_code(err_code), .bytes_done(bytes_done)
  );

  // Flash model: bench-owned mode controls, model-owned state
  logic [7:0]  mem [DEV];
  logic        pre_en = 1'b0;
  logic [AW-1:0] pre_addr = '0;
  logic [7:0]  pre_data = '0;
  int          busy_cfg = 0;
  logic        fault_mode = 1'b0;
  logic        stuck_mode = 1'b0;
  int          busy_left = 0;
  int          cmd_st = 0;
  logic        tog = 1'b0;
  logic [7:0]  pd = '0;

  always @(posedge clk) begin
    if (pre_en) mem[pre_addr] <= pre_data;
    if (fl_stb && fl_we) begin
      if (busy_left == 0) begin
        case (cmd_st)
          0: cmd_st <= (fl_addr == 12'h555 && fl_wdata == 8'hAA) ? 1 : 0;
          1: cmd_st <= (fl_addr == 12'h2AA && fl_wdata == 8'h55) ? 2 : 0;
          2: cmd_st <= (fl_addr == 12'h555 && fl_wdata == 8'hA0) ? 3 : 0;
          default: begin
            if (!fault_mode) mem[fl_addr] <= mem[fl_addr] & fl_wdata;
            pd        <= fl_wdata;
            busy_left <= busy_cfg;
            cmd_st    <= 0;
          end
        endcase
      end
    end else if (fl_stb) begin
      if (stuck_mode || busy_left > 0) begin
        fl_rdata <= {~pd[7], tog, fault_mode, 5'b0};
        tog      <= ~tog;
        if (busy_left > 0) busy_left <= busy_left - 1;
      end else begin
        fl_rdata <= mem[fl_addr];
      end
    end
  end

  // Monitor
  int n_wr = 0, n_rd = 0, n_done = 0, n_warn = 0, rd_since_wr = 0;
  logic [AW-1:0] wl_a [4];
  logic [7:0]    wl_d [4];
  always @(posedge clk) begin
    if (done) n_done <= n_done + 1;
    if (warn) n_warn <= n_warn + 1;
    if (fl_stb && fl_we) begin
      n_wr <= n_wr + 1;
      rd_since_wr <= 0;
      for (int i = 0; i < 3; i++) begin
        wl_a[i] <= wl_a[i+1];
        wl_d[i] <= wl_d[i+1];
      end
      wl_a[3] <= fl_addr;
      wl_d[3] <= fl_wdata;
    end else if (fl_stb) begin
      n_rd <= n_rd + 1;
      rd_since_wr <= rd_since_wr + 1;
    end
  end

  int checks = 0, fails = 0;
  logic finished = 1'b0;
  logic [7:0] src [16];

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic preload(input int a, input logic [7:0] v);
    @(negedge clk);
    pre_en = 1'b1; pre_addr = AW'(a); pre_data = v;
    @(negedge clk);
    pre_en = 1'b0;
  endtask

  task automatic run_req(input int a, input int n,
                         output int code, output int nb, output int taken);
    int idx = 0;
    int d0 = n_done;
    bit take;
    @(negedge clk);
    req_valid = 1'b1; req_addr = AW'(a); req_len = (AW+1)'(n);
    @(negedge clk);
    req_valid = 1'b0;
    code = -1; nb = -1;
    for (int g = 0; g < 40000; g++) begin
      if (done) begin
        code = int'(err_code);
        nb = int'(bytes_done);
        break;
      end
      dat_valid = (idx < n);
      dat_byte = src[idx % 16];
      take = dat_ready && dat_valid;
      @(negedge clk);
      if (take) idx++;
    end
    dat_valid = 1'b0;
    taken = idx;
    @(negedge clk);
    chk(n_done - d0 == 1, "R8", "done pulses per request", n_done - d0, 1);
  endtask

  task automatic t_reset();
    chk(req_ready == 1'b1, "R9", "req_ready after reset", int'(req_ready), 1);
    chk(done == 1'b0 && fl_stb == 1'b0 && dat_ready == 1'b0, "R8", "idle outputs after reset",
        int'({done, fl_stb, dat_ready}), 0);
  endtask

  task automatic t_zero_len();
    int code, nb, tk, r0, w0;
    r0 = n_rd; w0 = n_wr;
    run_req(100, 0, code, nb, tk);
    chk(code == 0, "R9", "zero length code", code, 0);
    chk(nb == 0, "R9", "zero length count", nb, 0);
    chk(n_rd == r0 && n_wr == w0, "R9", "zero length strobes", n_rd + n_wr - r0 - w0, 0);
  endtask

  task automatic t_range();
    int code, nb, tk, r0, w0;
    r0 = n_rd; w0 = n_wr;
    run_req(4000, 100, code, nb, tk);
    chk(code == 1, "R7", "over-range code", code, 1);
    chk(n_rd == r0 && n_wr == w0, "R7", "over-range strobes", n_rd + n_wr - r0 - w0, 0);
    chk(tk == 0, "R7", "over-range stream bytes taken", tk, 0);
    chk(nb == 0, "R7", "over-range count", nb, 0);
  endtask

  task automatic t_skip_boundary();
    int code, nb, tk, w0, r0;
    for (int i = 0; i < 6; i++) begin
      src[i] = 8'h30 + 8'(i);
      preload(4090 + i, src[i]);
    end
    w0 = n_wr; r0 = n_rd;
    run_req(4090, 6, code, nb, tk);
    chk(code == 0, "R7", "request ending at device end accepted", code, 0);
    chk(n_wr == w0, "R1", "writes for unchanged bytes", n_wr - w0, 0);
    chk(nb == 6, "R1", "skipped bytes counted", nb, 6);
    chk(n_rd - r0 == 6, "R1", "one read per unchanged byte", n_rd - r0, 6);
  endtask

  task automatic t_program();
    int code, nb, tk, w0, r0, wn0;
    busy_cfg = 5;
    for (int i = 0; i < 4; i++) begin
      src[i] = 8'h81 + 8'(i * 17);
      preload(16 + i, 8'hFF);
    end
    w0 = n_wr; r0 = n_rd; wn0 = n_warn;
    run_req(16, 4, code, nb, tk);
    chk(code == 0, "R6", "success code", code, 0);
    chk(nb == 4, "R8", "bytes completed", nb, 4);
    for (int i = 0; i < 4; i++)
      chk(mem[16+i] == src[i], "R9", "programmed byte at consecutive address",
          int'(mem[16+i]), int'(src[i]));
    chk(n_wr - w0 == 16, "R3", "four writes per byte", n_wr - w0, 16);
    chk(n_rd - r0 == 32, "R4", "reads with 5 busy polls", n_rd - r0, 32);
    chk(wl_a[0] == 12'h555 && wl_d[0] == 8'hAA, "R3", "first command write",
        int'({wl_a[0], wl_d[0]}), 'h555AA);
    chk(wl_a[1] == 12'h2AA && wl_d[1] == 8'h55, "R3", "second command write",
        int'({wl_a[1], wl_d[1]}), 'h2AA55);
    chk(wl_a[2] == 12'h555 && wl_d[2] == 8'hA0, "R3", "third command write",
        int'({wl_a[2], wl_d[2]}), 'h555A0);
    chk(wl_a[3] == 12'd19 && wl_d[3] == src[3], "R3", "data write",
        int'({wl_a[3], wl_d[3]}), int'({12'd19, src[3]}));
    chk(n_warn == wn0, "R2", "no warning when only clearing bits", n_warn - wn0, 0);
  endtask

  task automatic t_min_polls();
    int code, nb, tk, r0;
    busy_cfg = 0;
    src[0] = 8'h42;
    preload(40, 8'hFF);
    r0 = n_rd;
    run_req(40, 1, code, nb, tk);
    chk(code == 0 && mem[40] == 8'h42, "R4", "immediate-ready program", code, 0);
    chk(n_rd - r0 == 4, "R4", "three polls minimum plus pre-read", n_rd - r0, 4);
  endtask

  task automatic t_zero_to_one();
    int code, nb, tk, w0, wn0;
    busy_cfg = 2;
    src[0] = 8'h12; src[1] = 8'hF0; src[2] = 8'h55;
    preload(32, 8'hFF); preload(33, 8'h0F); preload(34, 8'hAA);
    w0 = n_wr; wn0 = n_warn;
    run_req(32, 3, code, nb, tk);
    chk(n_warn - wn0 == 1, "R2", "warning pulses", n_warn - wn0, 1);
    chk(n_wr - w0 == 8, "R2", "write still attempted", n_wr - w0, 8);
    chk(code == 3, "R6", "not-programmed code", code, 3);
    chk(nb == 1, "R8", "count stops at failure", nb, 1);
    chk(tk == 2, "R8", "stream stops after failing byte", tk, 2);
    chk(mem[34] == 8'hAA, "R8", "byte after failure untouched", int'(mem[34]), 'hAA);
  endtask

  task automatic t_fault();
    int code, nb, tk;
    busy_cfg = 3; fault_mode = 1'b1;
    src[0] = 8'h3C;
    preload(48, 8'hFF);
    run_req(48, 1, code, nb, tk);
    fault_mode = 1'b0;
    chk(code == 2, "R6", "internal-fault code from bit 5", code, 2);
    chk(nb == 0, "R8", "fault count", nb, 0);
  endtask

  task automatic t_timeout();
    int code, nb, tk;
    busy_cfg = 0; stuck_mode = 1'b1;
    src[0] = 8'h55;
    preload(64, 8'hFF);
    run_req(64, 1, code, nb, tk);
    stuck_mode = 1'b0;
    chk(rd_since_wr == PLIM, "R5", "polls at cap", rd_since_wr, PLIM);
    chk(code == 3, "R5", "capped poll result", code, 3);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_zero_len();
    t_range();
    t_skip_boundary();
    t_program();
    t_min_polls();
    t_zero_to_one();
    t_fault();
    t_timeout();
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL R8 watchdog actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

endmodule